// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks where each of the two ALU operands of a five-stage pipeline comes from while an instruction sits in execute. A result that an older instruction has computed but not yet written back can feed a younger instruction directly. That result can be in the execute/memory register (the previous instruction) or in the memory/writeback register (the one before it). The block compares the two source register numbers held in the decode/execute register against the destination numbers and write enables of those two later stages. It produces a 2-bit select for each operand and drives the selected operand values. The second source path also feeds the store data, so a store of a just-computed register writes the correct value.

All state in the pipeline changes on the rising edge only. A register read in decode therefore sees the old contents when writeback writes the same register in the same cycle. A second bypass corrects the two decode read ports: when the writeback stage writes the address being read, the write data replaces the stale register-file data. The whole block is combinational.

Top module: `fwd_bypass_unit`

## Requirements
- R1: When the memory-stage write enable is high, its destination is non-zero and it equals the first source number, `sel_a` is 2'b10 and `opnd_a` equals `mem_result`.
- R2: When the writeback-stage write enable is high, its destination is non-zero and it equals the first source number, and R1 does not apply, `sel_a` is 2'b01 and `opnd_a` equals `wb_value`.
- R3: When both later stages qualify for the same source, the memory-stage result wins (select 2'b10), because it is the younger value.
- R4: A destination of register 0 is never forwarded, whatever the write enables.
- R5: A stage whose write enable is low is never forwarded from, even when its destination matches.
- R6: When no stage qualifies, the select is 2'b00 and the operand equals the value read in decode (`ex_rs_val` or `ex_rt_val`); the select value 2'b11 never appears.
- R7: The second source follows the same rules through `sel_b` and `opnd_b`, independently of the first, and `store_data` always equals `opnd_b`.
- R8: On each decode read port, when the writeback write enable is high, its destination is non-zero and it equals the read address, the port output equals `wb_value`; otherwise it equals the raw register-file data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_idx | input | 5 | First source register number in execute |
| ex_rt_idx | input | 5 | Second source register number in execute |
| ex_rs_val | input | 32 | First source value read in decode |
| ex_rt_val | input | 32 | Second source value read in decode |
| mem_dst_idx | input | 5 | Destination register number in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_result | input | 32 | ALU result held in the memory stage |
| wb_dst_idx | input | 5 | Destination register number in writeback |
| wb_wr_en | input | 1 | Writeback-stage register write enable |
| wb_value | input | 32 | Value being written back |
| id_rd_idx_a | input | 5 | Decode read address, port A |
| id_rd_idx_b | input | 5 | Decode read address, port B |
| rf_rdata_a | input | 32 | Raw register-file data, port A |
| rf_rdata_b | input | 32 | Raw register-file data, port B |
| sel_a | output | 2 | Source select for operand A (00 file, 10 memory stage, 01 writeback) |
| sel_b | output | 2 | Source select for operand B, same encoding |
| opnd_a | output | 32 | Operand A to the ALU |
| opnd_b | output | 32 | Operand B to the ALU |
| store_data | output | 32 | Store data taken from the forwarded second source |
| id_val_a | output | 32 | Corrected decode read data, port A |
| id_val_b | output | 32 | Corrected decode read data, port B |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle as the stimulus, with no register on the way. The bench changes the inputs on the falling clock edge and samples one nanosecond later, well before the next rising edge. No check depends on an earlier cycle. Each scenario also holds the other stages at values that must not be chosen, so a wrong select shows up as a wrong operand value.

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_rs_idx,
  input  logic [REG_AW-1:0] ex_rt_idx,
  input  logic [DATA_W-1:0] ex_rs_val,
  input  logic [DATA_W-1:0] ex_rt_val,
  input  logic [REG_AW-1:0] mem_dst_idx,
  input  logic              mem_wr_en,
  input  logic [DATA_W-1:0] mem_result,
  input  logic [REG_AW-1:0] wb_dst_idx,
  input  logic              wb_wr_en,
  input  logic [DATA_W-1:0] wb_value,
  input  logic [REG_AW-1:0] id_rd_idx_a,
  input  logic [REG_AW-1:0] id_rd_idx_b,
  input  logic [DATA_W-1:0] rf_rdata_a,
  input  logic [DATA_W-1:0] rf_rdata_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] store_data,
  output logic [DATA_W-1:0] id_val_a,
  output logic [DATA_W-1:0] id_val_b
);

  localparam logic [1:0]        SRC_FILE = 2'b00;
  localparam logic [1:0]        SRC_MEM  = 2'b10;
  localparam logic [1:0]        SRC_WB   = 2'b01;
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic mem_live, wb_live;
  assign mem_live = mem_wr_en && (mem_dst_idx != ZERO_REG);
  assign wb_live  = wb_wr_en  && (wb_dst_idx  != ZERO_REG);

  function automatic logic [1:0] pick_src(input logic [REG_AW-1:0] src);
    if (mem_live && (mem_dst_idx == src))     return SRC_MEM;
    else if (wb_live && (wb_dst_idx == src))  return SRC_WB;
    else                                      return SRC_FILE;
  endfunction

  function automatic logic [DATA_W-1:0] route(input logic [1:0] sel,
                                              input logic [DATA_W-1:0] file_val);
    case (sel)
      SRC_MEM: return mem_result;
      SRC_WB:  return wb_value;
      default: return file_val;
    endcase
  endfunction

  assign sel_a = pick_src(ex_rs_idx);
  assign sel_b = pick_src(ex_rt_idx);

  assign opnd_a     = route(sel_a, ex_rs_val);
  assign opnd_b     = route(sel_b, ex_rt_val);
  assign store_data = opnd_b;

  assign id_val_a = (wb_live && (wb_dst_idx == id_rd_idx_a)) ? wb_value : rf_rdata_a;
  assign id_val_b = (wb_live && (wb_dst_idx == id_rd_idx_b)) ? wb_value : rf_rdata_b;

endmodule

module fwd_bypass_unit_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_rs_idx,
  input logic [REG_AW-1:0] ex_rt_idx,
  input logic [REG_AW-1:0] mem_dst_idx,
  input logic              mem_wr_en,
  input logic [DATA_W-1:0] mem_result,
  input logic [REG_AW-1:0] wb_dst_idx,
  input logic              wb_wr_en,
  input logic [DATA_W-1:0] wb_value,
  input logic [REG_AW-1:0] id_rd_idx_a,
  input logic [DATA_W-1:0] rf_rdata_a,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] store_data,
  input logic [DATA_W-1:0] id_val_a
);

  always_comb begin
    if (mem_wr_en && mem_dst_idx != 0 && mem_dst_idx == ex_rs_idx)
      assert_mem_first_R1: assert (sel_a == 2'b10 && opnd_a == mem_result)
        else $error("memory-stage forward missed on operand A");
    if (wb_wr_en && wb_dst_idx != 0 && wb_dst_idx == ex_rs_idx &&
        !(mem_wr_en && mem_dst_idx != 0 && mem_dst_idx == ex_rs_idx))
      assert_wb_second_R2: assert (sel_a == 2'b01 && opnd_a == wb_value)
        else $error("writeback forward missed on operand A");
    if (ex_rs_idx == 0)
      assert_no_zero_fwd_R4: assert (sel_a == 2'b00)
        else $error("register 0 forwarded");
    assert_no_bad_sel_R6: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("select 11 produced");
    if (!mem_wr_en && !wb_wr_en)
      assert_no_fwd_disabled_R5: assert (sel_a == 2'b00 && sel_b == 2'b00)
        else $error("forward while no stage writes");
    assert_store_tap_R7: assert (store_data == opnd_b)
      else $error("store data differs from operand B");
    if (wb_wr_en && wb_dst_idx != 0 && wb_dst_idx == id_rd_idx_a)
      assert_rf_bypass_R8: assert (id_val_a == wb_value)
        else $error("decode read bypass missed");
    else
      assert_rf_pass_R8: assert (id_val_a == rf_rdata_a)
        else $error("decode read altered without a write");
  end

endmodule

bind fwd_bypass_unit fwd_bypass_unit_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) chk (
  .ex_rs_idx(ex_rs_idx), .ex_rt_idx(ex_rt_idx),
  .mem_dst_idx(mem_dst_idx), .mem_wr_en(mem_wr_en), .mem_result(mem_result),
  .wb_dst_idx(wb_dst_idx), .wb_wr_en(wb_wr_en), .wb_value(wb_value),
  .id_rd_idx_a(id_rd_idx_a), .rf_rdata_a(rf_rdata_a),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .store_data(store_data), .id_val_a(id_val_a)
);

// File: tb/fwd_bypass_unit_test.sv
module fwd_bypass_unit_test;

  localparam logic [31:0] V_RS  = 32'h1111_0003;
  localparam logic [31:0] V_RT  = 32'h2222_0004;
  localparam logic [31:0] V_MEM = 32'hAAAA_0001;
  localparam logic [31:0] V_WB  = 32'hBBBB_0002;
  localparam logic [31:0] V_RFA = 32'h3333_0005;
  localparam logic [31:0] V_RFB = 32'h4444_0006;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  ex_rs_idx, ex_rt_idx, mem_dst_idx, wb_dst_idx, id_rd_idx_a, id_rd_idx_b;
  logic        mem_wr_en, wb_wr_en;
  logic [31:0] ex_rs_val, ex_rt_val, mem_result, wb_value, rf_rdata_a, rf_rdata_b;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b, store_data, id_val_a, id_val_b;

  int n_chk = 0;
  int n_bad = 0;

  fwd_bypass_unit uut (
    .ex_rs_idx(ex_rs_idx), .ex_rt_idx(ex_rt_idx),
    .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val),
    .mem_dst_idx(mem_dst_idx), .mem_wr_en(mem_wr_en), .mem_result(mem_result),
    .wb_dst_idx(wb_dst_idx), .wb_wr_en(wb_wr_en), .wb_value(wb_value),
    .id_rd_idx_a(id_rd_idx_a), .id_rd_idx_b(id_rd_idx_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .store_data(store_data), .id_val_a(id_val_a), .id_val_b(id_val_b)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic setup(input logic [4:0] rs, input logic [4:0] rt,
                       input logic [4:0] md, input logic me,
                       input logic [4:0] wd, input logic we);
    @(negedge clk);
    ex_rs_idx = rs; ex_rt_idx = rt;
    mem_dst_idx = md; mem_wr_en = me;
    wb_dst_idx = wd; wb_wr_en = we;
    #1;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    ex_rs_val = V_RS; ex_rt_val = V_RT; mem_result = V_MEM; wb_value = V_WB;
    rf_rdata_a = V_RFA; rf_rdata_b = V_RFB;
    id_rd_idx_a = 5'd0; id_rd_idx_b = 5'd0;
    setup(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R6 idle sel_a", {30'd0, sel_a}, 32'd0);
    chk("R6 idle sel_b", {30'd0, sel_b}, 32'd0);
    chk("R8 idle id_val_a", id_val_a, V_RFA);
  endtask

  task automatic t_mem_forward;
    setup(5'd7, 5'd9, 5'd7, 1'b1, 5'd3, 1'b1);
    chk("R1 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R1 opnd_a", opnd_a, V_MEM);
    chk("R7 opnd_b untouched", opnd_b, V_RT);
  endtask

  task automatic t_wb_forward;
    setup(5'd4, 5'd9, 5'd12, 1'b1, 5'd4, 1'b1);
    chk("R2 sel_a", {30'd0, sel_a}, 32'd1);
    chk("R2 opnd_a", opnd_a, V_WB);
  endtask

  task automatic t_priority;
    setup(5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1);
    chk("R3 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R3 opnd_a", opnd_a, V_MEM);
    chk("R3 sel_b", {30'd0, sel_b}, 32'd2);
    chk("R3 opnd_b", opnd_b, V_MEM);
  endtask

  task automatic t_zero_reg;
    setup(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R4 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R4 opnd_a", opnd_a, V_RS);
    chk("R4 opnd_b", opnd_b, V_RT);
    @(negedge clk); id_rd_idx_a = 5'd0; #1;
    chk("R4 id_val_a zero", id_val_a, V_RFA);
  endtask

  task automatic t_disabled;
    setup(5'd8, 5'd8, 5'd8, 1'b0, 5'd8, 1'b0);
    chk("R5 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R5 opnd_a", opnd_a, V_RS);
    chk("R5 opnd_b", opnd_b, V_RT);
    setup(5'd8, 5'd2, 5'd8, 1'b0, 5'd8, 1'b1);
    chk("R5 falls to wb", opnd_a, V_WB);
  endtask

  task automatic t_no_match;
    setup(5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1);
    chk("R6 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R6 opnd_a", opnd_a, V_RS);
    chk("R6 sel_b", {30'd0, sel_b}, 32'd0);
  endtask

  task automatic t_rt_path;
    setup(5'd6, 5'd14, 5'd6, 1'b1, 5'd14, 1'b1);
    chk("R7 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R7 sel_b", {30'd0, sel_b}, 32'd1);
    chk("R7 opnd_b", opnd_b, V_WB);
    chk("R7 store_data", store_data, V_WB);
    setup(5'd1, 5'd15, 5'd15, 1'b1, 5'd1, 1'b1);
    chk("R7 store_data mem", store_data, V_MEM);
    chk("R7 opnd_a wb", opnd_a, V_WB);
  endtask

  task automatic t_rf_bypass;
    setup(5'd0, 5'd0, 5'd0, 1'b0, 5'd17, 1'b1);
    @(negedge clk); id_rd_idx_a = 5'd17; id_rd_idx_b = 5'd18; #1;
    chk("R8 port A bypass", id_val_a, V_WB);
    chk("R8 port B pass", id_val_b, V_RFB);
    @(negedge clk); id_rd_idx_b = 5'd17; wb_wr_en = 1'b0; #1;
    chk("R8 enable low A", id_val_a, V_RFA);
    chk("R8 enable low B", id_val_b, V_RFB);
    @(negedge clk); wb_wr_en = 1'b1; #1;
    chk("R8 port B bypass", id_val_b, V_WB);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_mem_forward();
        t_wb_forward();
        t_priority();
        t_zero_reg();
        t_disabled();
        t_no_match();
        t_rt_path();
        t_rf_bypass();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule